// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block keeps the loads of an out-of-order core in a circular queue in program order, from dispatch until retirement. Loads may execute before older stores have resolved their addresses. When a load executes, it writes its address into its entry and marks the entry as executed. Later, when an older store learns its address, the store presents that address together with its position in the load sequence. The queue then compares the address against every executed load that is younger than the store.

When one or more of those loads match, a load has read memory too early. One cycle after the store is presented, the block reports the queue index of the oldest matching load. In that same cycle it cuts the tail back to that load, so the offending load and every younger one leave the queue. The pipeline then refetches from that load. Loads that have not executed yet are not compared, because they will pick up the store's value later.

Top module: `load_order_guard`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0 and `viol_valid` is 0.
- R2: Each accepted `alloc_valid` gives the load the index shown on `alloc_idx`, and the next index is one higher modulo DEPTH. `alloc_ready` falls once DEPTH loads are held. An allocation request while the queue is full is ignored.
- R3: `retire_valid` frees the oldest entry. A retire request on an empty queue is ignored.
- R4: A store whose `st_addr` equals the recorded address of an executed load younger than the store makes `viol_valid` go high on the clock edge after the store is presented, with that load's index on `viol_idx`. The pulse lasts one cycle unless another store also matches.
- R5: `st_pos` is a pointer of log2(DEPTH)+1 bits, counted the same way as allocation: the first allocation after reset is 0, and the count wraps at 2*DEPTH. A load counts as younger than the store when its pointer is at or after `st_pos`. Loads before `st_pos` never match, and a store whose `st_pos` equals the tail matches nothing.
- R6: A load that has not executed never matches. This includes a load whose `exec_valid` arrives in the same cycle as the store.
- R7: When several younger executed loads match, `viol_idx` names the one nearest the head.
- R8: On a violation the tail moves back to the flagged load, so `alloc_idx` equals `viol_idx` and the flagged load and all younger loads are removed. An allocation or retire request in the detection cycle is dropped.
- R9: A store that matches nothing leaves `viol_valid` low and does not change the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch a new load into the queue |
| alloc_ready | output | 1 | The queue has a free entry |
| alloc_idx | output | IW | Index the next allocated load will receive (tail) |
| retire_valid | input | 1 | Retire the load at the head |
| exec_valid | input | 1 | A queued load has executed |
| exec_idx | input | IW | Queue index of the executing load |
| exec_addr | input | AW | Address read by the executing load |
| st_valid | input | 1 | A store has resolved its address |
| st_pos | input | IW+1 | Load pointer of the first load younger than the store |
| st_addr | input | AW | Resolved store address |
| viol_valid | output | 1 | Ordering violation detected (registered) |
| viol_idx | output | IW | Index of the oldest violating load |

## Verification
The search is driven with stores whose address matches nothing, matches only loads older than the store, matches a load executing in the same cycle, and matches several younger loads. Together these separate the age bound, the executed filter and the oldest-first choice. A second sequence fills the queue, wraps it, and fires a multi-match store together with allocate and retire requests. The occupancy seen afterwards shows whether the tail truncation was exact and whether the simultaneous requests were really dropped. A final store placed at the tail pointer shows that a store with no younger loads flags nothing, even when its address equals a live entry.

// File: rtl/load_order_guard.sv
module load_order_guard #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_idx,
  input  logic          retire_valid,
  input  logic          exec_valid,
  input  logic [IW-1:0] exec_idx,
  input  logic [AW-1:0] exec_addr,
  input  logic          st_valid,
  input  logic [PW-1:0] st_pos,
  input  logic [AW-1:0] st_addr,
  output logic          viol_valid,
  output logic [IW-1:0] viol_idx
);

  logic [PW-1:0]    head_q, tail_q, cnt, st_off, hit_off;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic             hit_any;

  assign cnt         = tail_q - head_q;
  assign st_off      = st_pos - head_q;
  assign alloc_ready = cnt != PW'(DEPTH);
  assign alloc_idx   = tail_q[IW-1:0];

  always_comb begin
    hit_any = 1'b0;
    hit_off = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [PW-1:0] kk;
      logic [PW-1:0] p;
      kk = PW'(k);
      p  = head_q + kk;
      if (st_valid && kk < cnt && kk >= st_off && done_q[p[IW-1:0]] &&
          addr_q[p[IW-1:0]] == st_addr) begin
        hit_any = 1'b1;
        hit_off = kk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      done_q     <= '0;
      viol_valid <= 1'b0;
      viol_idx   <= '0;
    end else begin
      if (exec_valid) done_q[exec_idx] <= 1'b1;
      if (hit_any) begin
        logic [PW-1:0] cut;
        cut        = head_q + hit_off;
        tail_q     <= cut;
        viol_valid <= 1'b1;
        viol_idx   <= cut[IW-1:0];
      end else begin
        viol_valid <= 1'b0;
        if (alloc_valid && alloc_ready) begin
          tail_q <= tail_q + 1'b1;
          done_q[tail_q[IW-1:0]] <= 1'b0;
        end
        if (retire_valid && cnt != '0) head_q <= head_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (exec_valid) addr_q[exec_idx] <= exec_addr;
  end

  p_viol_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(st_valid));

  p_no_viol_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !viol_valid);

  p_flush_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> alloc_idx == viol_idx);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PW'(DEPTH));

  p_empty_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !alloc_valid) |=> cnt == '0);

endmodule

// File: tb/load_order_guard_test.sv
module load_order_guard_test;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, retire_valid = 0, exec_valid = 0, st_valid = 0;
  logic [2:0] exec_idx = 0;
  logic [15:0] exec_addr = 0, st_addr = 0;
  logic [3:0] st_pos = 0;
  logic alloc_ready, viol_valid;
  logic [2:0] alloc_idx, viol_idx;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  load_order_guard #(.DEPTH(8), .AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx), .retire_valid(retire_valid), .exec_valid(exec_valid),
    .exec_idx(exec_idx), .exec_addr(exec_addr), .st_valid(st_valid), .st_pos(st_pos),
    .st_addr(st_addr), .viol_valid(viol_valid), .viol_idx(viol_idx));

  typedef struct packed {
    logic a, r, e; logic [2:0] ei; logic [15:0] ea;
    logic s; logic [3:0] sp; logic [15:0] sa;
    logic xv; logic [2:0] xi; logic [2:0] xa; logic xr;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1,0,0,0,16'h0,  0,0,16'h0,  0,0,1,1},  // R2 alloc idx0
    '{1,0,0,0,16'h0,  0,0,16'h0,  0,0,2,1},
    '{1,0,0,0,16'h0,  0,0,16'h0,  0,0,3,1},
    '{1,0,0,0,16'h0,  0,0,16'h0,  0,0,4,1},
    '{0,0,1,1,16'h44, 0,0,16'h0,  0,0,4,1},
    '{0,0,1,3,16'h44, 0,0,16'h0,  0,0,4,1},
    '{0,0,1,2,16'h20, 0,0,16'h0,  0,0,4,1},
    '{0,0,0,0,16'h0,  1,1,16'h60, 0,0,4,1},  // R9 no match
    '{0,0,0,0,16'h0,  1,2,16'h44, 1,3,3,1},  // R5 idx1 older, idx3 flagged
    '{0,0,1,0,16'h20, 1,0,16'h20, 1,2,2,1},  // R6 idx0 executes same cycle
    '{0,0,0,0,16'h0,  1,0,16'h20, 1,0,0,1},  // R4 idx0 now matches
    '{0,1,0,0,16'h0,  0,0,16'h0,  0,0,0,1},  // R3 retire on empty
    '{1,0,0,0,16'h0,  0,0,16'h0,  0,0,1,1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic a, logic r, logic e, logic [2:0] ei, logic [15:0] ea,
                      logic s, logic [3:0] sp, logic [15:0] sa);
    alloc_valid = a; retire_valid = r; exec_valid = e; exec_idx = ei; exec_addr = ea;
    st_valid = s; st_pos = sp; st_addr = sa;
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0; retire_valid = 0; exec_valid = 0; st_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 viol_valid", viol_valid, 0);

    for (int i = 0; i < 13; i++) begin
      step(TBL[i].a, TBL[i].r, TBL[i].e, TBL[i].ei, TBL[i].ea, TBL[i].s, TBL[i].sp, TBL[i].sa);
      chk($sformatf("R4/R9 viol_valid row %0d", i), viol_valid, TBL[i].xv);
      if (TBL[i].xv) chk($sformatf("R7 viol_idx row %0d", i), viol_idx, TBL[i].xi);
      chk($sformatf("R8/R2 alloc_idx row %0d", i), alloc_idx, TBL[i].xa);
      chk($sformatf("R2 alloc_ready row %0d", i), alloc_ready, TBL[i].xr);
    end

    // R2: fill, full, ignored allocation
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 fill alloc_idx", alloc_idx, (i + 1) % 8);
      chk("R2 fill alloc_ready", alloc_ready, i < 7);
    end
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 full alloc ignored idx", alloc_idx, 0);
    chk("R2 full alloc ignored ready", alloc_ready, 0);

    // R3: retire three, allocate two (wraps)
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 retire frees", alloc_ready, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 wrap alloc_idx", alloc_idx, 2);

    step(0, 0, 1, 3'd6, 16'hAA, 0, 0, 0);
    step(0, 0, 1, 3'd0, 16'hAA, 0, 0, 0);
    step(0, 0, 1, 3'd1, 16'hAA, 0, 0, 0);
    step(0, 0, 1, 3'd4, 16'hBB, 0, 0, 0);

    // R7/R8: multi-match across the wrap, with alloc and retire dropped
    step(1, 1, 0, 0, 0, 1, 4'd5, 16'hAA);
    chk("R7 multi viol_valid", viol_valid, 1);
    chk("R7 oldest viol_idx", viol_idx, 6);
    chk("R8 tail truncated", alloc_idx, 6);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 single-cycle pulse", viol_valid, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 occupancy after flush", alloc_ready, 1);
    end
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 retire dropped, full now", alloc_ready, 0);
    chk("R8 alloc_idx after refill", alloc_idx, 3);

    // R5: store at tail pointer has no younger loads
    step(0, 0, 0, 0, 0, 1, 4'd11, 16'hBB);
    chk("R5 store at tail no viol", viol_valid, 0);
    step(0, 0, 0, 0, 0, 1, 4'd4, 16'hBB);
    chk("R4 viol_valid", viol_valid, 1);
    chk("R4 viol_idx", viol_idx, 4);
    chk("R8 alloc_idx", alloc_idx, 4);

    finish_run();
  end
endmodule